// File: doc/BRIEF.md
# Mailbox Doorbell Console Bridge

This block carries a byte-wide console between a local agent and a remote peer. Four 32-bit registers form the link: a receive mailbox that the peer fills, a transmit mailbox that the local side fills, an incoming doorbell that the peer rings and an outgoing doorbell that the local side rings. The peer reads and clears the transmit mailbox and the outgoing doorbell. The block reads the receive mailbox and the incoming doorbell.

On the local side a character strobed into the transmit path is turned into a tagged mailbox word. The block then announces it on the outgoing doorbell. A newline is followed by a carriage return without further action from the sender. Incoming doorbell messages are decoded in hardware. A liveness probe is echoed. A connect request flushes the receive ring and marks the link up. A disconnect request marks the link down. A data message moves the low byte of the receive mailbox into a 256-entry ring, which the local consumer drains one byte per read strobe.

Flow control needs no extra wire. The receive mailbox is zeroed after each stored byte, which tells the peer it may send again. When the ring comes within a few entries of capacity, the zeroing is held back. It is done later, once the consumer has drained enough bytes.

Top module: `mbox_console_bridge`

## Requirements
- R1: After reset all four link registers read zero, the ring is empty (`rx_avail` low), `connected` is low and `tx_ready` is high.
- R2: A character C accepted on the transmit side appears in the transmit mailbox as 0x80000000 | C, bit 31 being the valid tag. In the same cycle the outgoing doorbell is set to the data code 0x5.
- R3: A character is placed in the transmit mailbox only while that mailbox and the outgoing doorbell both read zero. A nonzero transmit mailbox keeps its value until the peer clears it.
- R4: When the newline character 0x0A is sent, a carriage return 0x0D follows it on its own. The return waits until the mailbox and doorbell are free again. No further character follows it.
- R5: An incoming doorbell value of 0x1 (alive) is answered by setting the outgoing doorbell to 0x1 in the next cycle, once the outgoing doorbell is zero.
- R6: An incoming 0x2 (connect) empties the ring, drops the full condition, zeroes the receive mailbox and raises `connected`. An incoming 0x3 (disconnect) lowers `connected`.
- R7: An incoming 0x5 (data) stores bits 7:0 of the receive mailbox at the write pointer. Bytes are read back in arrival order, and both pointers wrap modulo 256.
- R8: After a store the occupancy is written minus read, modulo 256. If it is at most 252, the receive mailbox is zeroed. If it exceeds 252, the block marks the ring full and leaves the receive mailbox untouched.
- R9: A read that takes the occupancy below 252 while the ring is marked full clears the full mark and zeroes the receive mailbox. A read that leaves 252 or more changes neither.
- R10: A read strobe while the ring is empty returns nothing and leaves the read pointer where it was. The next stored byte is the next one read.
- R11: Every incoming doorbell value except a pending alive is consumed in the cycle after it arrives, so the register reads zero again. Unknown codes are dropped without other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| peer_rx_mbox_we | input | 1 | Peer writes the receive mailbox |
| peer_rx_mbox_wdata | input | 32 | Receive mailbox write value |
| rx_mbox_q | output | 32 | Receive mailbox contents, read by the peer |
| peer_tx_mbox_clr | input | 1 | Peer zeroes the transmit mailbox |
| tx_mbox_q | output | 32 | Transmit mailbox contents |
| peer_db_we | input | 1 | Peer rings the incoming doorbell |
| peer_db_wdata | input | 32 | Incoming doorbell value (bits are OR-ed in) |
| in_db_q | output | 32 | Incoming doorbell contents |
| peer_out_db_we | input | 1 | Peer write-one-to-clear of the outgoing doorbell |
| peer_out_db_wdata | input | 32 | Clear mask for the outgoing doorbell |
| out_db_q | output | 32 | Outgoing doorbell contents |
| tx_valid | input | 1 | Local character strobe |
| tx_char | input | 8 | Local character |
| tx_ready | output | 1 | Transmit path can accept a character |
| rx_rd | input | 1 | Local read strobe for the ring |
| rx_data | output | 8 | Byte at the ring read pointer |
| rx_avail | output | 1 | Ring holds at least one byte |
| connected | output | 1 | Link marked up by the peer |

## Verification
The assertions take it for granted that the peer behaves as a well-mannered partner. It rings a new doorbell only after the previous one has been consumed. It writes the receive mailbox only while it reads zero. It never sends a data message into a ring that already holds 255 bytes. The stimulus keeps to this by pausing for the consume cycle after every ring. It stops feeding bytes as soon as the mailbox is left nonzero at the near-full mark, and it drains before sending more. Transmit stimulus waits for `tx_ready` and clears both outgoing registers together, as a peer reading out a character would.

// File: rtl/mcb_pkg.sv
`timescale 1ns/1ps
package mcb_pkg;

  localparam int unsigned WORD_W = 32;

  localparam logic [WORD_W-1:0] MSG_ALIVE      = 32'h0000_0001;
  localparam logic [WORD_W-1:0] MSG_CONNECT    = 32'h0000_0002;
  localparam logic [WORD_W-1:0] MSG_DISCONNECT = 32'h0000_0003;
  localparam logic [WORD_W-1:0] MSG_DATA       = 32'h0000_0005;

  localparam logic [WORD_W-1:0] TX_TAG = 32'h8000_0000;

  localparam logic [7:0] CHAR_NEWLINE = 8'h0A;
  localparam logic [7:0] CHAR_RETURN  = 8'h0D;

  typedef struct packed {
    logic echo_alive;
    logic link_up;
    logic link_down;
    logic store;
    logic consume;
  } db_action_t;

endpackage

// File: rtl/mcb_db_decode.sv
`timescale 1ns/1ps
module mcb_db_decode
  import mcb_pkg::*;
(
  input  logic [WORD_W-1:0] in_db,
  input  logic              out_db_idle,
  output db_action_t        act
);

  always_comb begin
    act = '0;
    if (in_db != '0) begin
      unique case (in_db)
        MSG_ALIVE: begin
          act.echo_alive = out_db_idle;
          act.consume    = out_db_idle;
        end
        MSG_CONNECT: begin
          act.link_up = 1'b1;
          act.consume = 1'b1;
        end
        MSG_DISCONNECT: begin
          act.link_down = 1'b1;
          act.consume   = 1'b1;
        end
        MSG_DATA: begin
          act.store   = 1'b1;
          act.consume = 1'b1;
        end
        default: begin
          act.consume = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/mcb_ring.sv
`timescale 1ns/1ps
module mcb_ring #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned MARGIN = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_byte,
  output logic              avail,
  output logic              mbox_clear
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [AW-1:0] THRESH = AW'(DEPTH - MARGIN);
  localparam logic [AW-1:0] BRIM   = AW'(DEPTH - 1);
  localparam logic [AW-1:0] ONE    = AW'(1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_n;
  logic [AW-1:0] rd_ptr_q, rd_ptr_n;
  logic          full_q, full_n;
  logic          rd_fire;
  logic [AW-1:0] occ_q, occ_n;
  logic          release_n;

  assign avail   = (wr_ptr_q != rd_ptr_q);
  assign rd_byte = mem[rd_ptr_q];
  assign rd_fire = rd_en && avail && !flush;
  assign occ_q   = wr_ptr_q - rd_ptr_q;

  always_comb begin
    wr_ptr_n   = wr_ptr_q;
    rd_ptr_n   = rd_ptr_q;
    full_n     = full_q;
    release_n  = 1'b0;
    mbox_clear = 1'b0;
    if (flush) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      full_n   = 1'b0;
    end else begin
      if (wr_en)   wr_ptr_n = wr_ptr_q + ONE;
      if (rd_fire) rd_ptr_n = rd_ptr_q + ONE;
      if (wr_en) begin
        full_n     = (occ_n > THRESH);
        mbox_clear = !(occ_n > THRESH);
      end else if (rd_fire && full_q && (occ_n < THRESH)) begin
        full_n     = 1'b0;
        release_n  = 1'b1;
        mbox_clear = 1'b1;
      end
    end
  end

  assign occ_n = wr_ptr_n - rd_ptr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      full_q   <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      rd_ptr_q <= rd_ptr_n;
      full_q   <= full_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) mem[wr_ptr_q] <= wr_byte;
  end

  // R8: while marked full the occupancy never drops below the threshold
  assert_full_band_R8: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> (occ_q >= THRESH));

  // R10: an empty read strobe leaves the read pointer alone
  assert_empty_read_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !avail && !flush) |=> $stable(rd_ptr_q));

  // R7: the peer never overruns a ring holding DEPTH-1 bytes
  assert_no_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |-> (occ_q != BRIM));

  // R9: a release happens only on a read
  assert_release_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    release_n |-> rd_en);

endmodule

// File: rtl/mcb_tx.sv
`timescale 1ns/1ps
module mcb_tx
  import mcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_char,
  input  logic              path_idle,
  input  logic              blocked,
  output logic              ready,
  output logic              launch,
  output logic [WORD_W-1:0] launch_word
);

  logic       hold_vld_q, hold_vld_n;
  logic [7:0] hold_chr_q, hold_chr_n;
  logic       cr_pend_q, cr_pend_n;
  logic       accept;

  assign ready       = !hold_vld_q;
  assign accept      = in_valid && !hold_vld_q;
  assign launch      = hold_vld_q && path_idle && !blocked;
  assign launch_word = TX_TAG | {{(WORD_W-8){1'b0}}, hold_chr_q};

  always_comb begin
    hold_vld_n = hold_vld_q;
    hold_chr_n = hold_chr_q;
    cr_pend_n  = cr_pend_q;
    if (launch) begin
      if (cr_pend_q) begin
        hold_chr_n = CHAR_RETURN;
        cr_pend_n  = 1'b0;
      end else begin
        hold_vld_n = 1'b0;
      end
    end
    if (accept) begin
      hold_vld_n = 1'b1;
      hold_chr_n = in_char;
      cr_pend_n  = (in_char == CHAR_NEWLINE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld_q <= 1'b0;
      hold_chr_q <= '0;
      cr_pend_q  <= 1'b0;
    end else begin
      hold_vld_q <= hold_vld_n;
      hold_chr_q <= hold_chr_n;
      cr_pend_q  <= cr_pend_n;
    end
  end

  // R4: after a newline goes out the path stays busy for the return
  assert_return_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && launch_word[7:0] == CHAR_NEWLINE) |=> !ready);

endmodule

// File: rtl/mbox_console_bridge.sv
`timescale 1ns/1ps
module mbox_console_bridge
  import mcb_pkg::*;
#(
  parameter int unsigned RING_DEPTH  = 256,
  parameter int unsigned RING_MARGIN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        peer_rx_mbox_we,
  input  logic [31:0] peer_rx_mbox_wdata,
  output logic [31:0] rx_mbox_q,
  input  logic        peer_tx_mbox_clr,
  output logic [31:0] tx_mbox_q,
  input  logic        peer_db_we,
  input  logic [31:0] peer_db_wdata,
  output logic [31:0] in_db_q,
  input  logic        peer_out_db_we,
  input  logic [31:0] peer_out_db_wdata,
  output logic [31:0] out_db_q,
  input  logic        tx_valid,
  input  logic [7:0]  tx_char,
  output logic        tx_ready,
  input  logic        rx_rd,
  output logic [7:0]  rx_data,
  output logic        rx_avail,
  output logic        connected
);

  db_action_t  act;
  logic        ring_clear;
  logic        tx_launch;
  logic [31:0] tx_word;
  logic [31:0] rx_mbox_n, tx_mbox_n, in_db_n, out_db_n;
  logic        conn_n;
  logic        path_idle;

  assign path_idle = (tx_mbox_q == '0) && (out_db_q == '0);

  mcb_db_decode i_decode (
    .in_db       (in_db_q),
    .out_db_idle (out_db_q == '0),
    .act         (act)
  );

  mcb_ring #(
    .DEPTH  (RING_DEPTH),
    .MARGIN (RING_MARGIN),
    .DATA_W (8)
  ) i_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (act.link_up),
    .wr_en      (act.store),
    .wr_byte    (rx_mbox_q[7:0]),
    .rd_en      (rx_rd),
    .rd_byte    (rx_data),
    .avail      (rx_avail),
    .mbox_clear (ring_clear)
  );

  mcb_tx i_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (tx_valid),
    .in_char     (tx_char),
    .path_idle   (path_idle),
    .blocked     (act.echo_alive),
    .ready       (tx_ready),
    .launch      (tx_launch),
    .launch_word (tx_word)
  );

  always_comb begin
    rx_mbox_n = rx_mbox_q;
    if (peer_rx_mbox_we)                rx_mbox_n = peer_rx_mbox_wdata;
    else if (act.link_up || ring_clear) rx_mbox_n = '0;

    tx_mbox_n = tx_mbox_q;
    if (tx_launch)             tx_mbox_n = tx_word;
    else if (peer_tx_mbox_clr) tx_mbox_n = '0;

    in_db_n = (act.consume ? '0 : in_db_q) | (peer_db_we ? peer_db_wdata : '0);

    out_db_n = out_db_q;
    if (act.echo_alive)     out_db_n = MSG_ALIVE;
    else if (tx_launch)     out_db_n = MSG_DATA;
    else if (peer_out_db_we) out_db_n = out_db_q & ~peer_out_db_wdata;

    conn_n = connected;
    if (act.link_up)        conn_n = 1'b1;
    else if (act.link_down) conn_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_mbox_q <= '0;
      tx_mbox_q <= '0;
      in_db_q   <= '0;
      out_db_q  <= '0;
      connected <= 1'b0;
    end else begin
      rx_mbox_q <= rx_mbox_n;
      tx_mbox_q <= tx_mbox_n;
      in_db_q   <= in_db_n;
      out_db_q  <= out_db_n;
      connected <= conn_n;
    end
  end

  // R3: a loaded transmit mailbox is only changed by the peer
  assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mbox_q != '0 && !peer_tx_mbox_clr) |=> $stable(tx_mbox_q));

  // R2: every word in the transmit mailbox carries the valid tag
  assert_tx_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mbox_q != '0) |-> tx_mbox_q[31]);

  // R5: an alive probe with a free outgoing doorbell is echoed next cycle
  assert_alive_echo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_db_q == MSG_ALIVE && out_db_q == '0) |=> (out_db_q == MSG_ALIVE));

  // R6: connect zeroes the receive mailbox and marks the link up
  assert_connect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_db_q == MSG_CONNECT && !peer_rx_mbox_we) |=> (rx_mbox_q == '0 && connected));

  // R11: non-alive doorbell values are consumed in one cycle
  assert_db_consumed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_db_q != '0 && in_db_q != MSG_ALIVE && !peer_db_we) |=> (in_db_q == '0));

endmodule

// File: tb/test_mbox_console_bridge.sv
`timescale 1ns/1ps
module test_mbox_console_bridge;

  logic        clk;
  logic        rst_n;
  logic        peer_rx_mbox_we;
  logic [31:0] peer_rx_mbox_wdata;
  logic [31:0] rx_mbox_q;
  logic        peer_tx_mbox_clr;
  logic [31:0] tx_mbox_q;
  logic        peer_db_we;
  logic [31:0] peer_db_wdata;
  logic [31:0] in_db_q;
  logic        peer_out_db_we;
  logic [31:0] peer_out_db_wdata;
  logic [31:0] out_db_q;
  logic        tx_valid;
  logic [7:0]  tx_char;
  logic        tx_ready;
  logic        rx_rd;
  logic [7:0]  rx_data;
  logic        rx_avail;
  logic        connected;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  mbox_console_bridge i_mbox_console_bridge (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // stimulus word, expected stored byte
  localparam logic [39:0] VEC [8] = '{
    {32'h8000_0041, 8'h41}, {32'h8000_007A, 8'h7A},
    {32'h1234_56FF, 8'hFF}, {32'h8000_0000, 8'h00},
    {32'hFFFF_FF0A, 8'h0A}, {32'h8000_0155, 8'h55},
    {32'h0000_00A5, 8'hA5}, {32'h8765_4380, 8'h80}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic send_word(input logic [31:0] w);
    @(negedge clk);
    peer_rx_mbox_we = 1; peer_rx_mbox_wdata = w;
    peer_db_we = 1; peer_db_wdata = 32'h5;
    @(negedge clk);
    peer_rx_mbox_we = 0; peer_db_we = 0;
    @(negedge clk);
  endtask

  task automatic ring_db(input logic [31:0] code);
    @(negedge clk);
    peer_db_we = 1; peer_db_wdata = code;
    @(negedge clk);
    peer_db_we = 0;
    @(negedge clk);
  endtask

  task automatic read_one();
    rx_rd = 1;
    @(negedge clk);
    rx_rd = 0;
    @(negedge clk);
  endtask

  task automatic tx_send(input logic [7:0] c);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1; tx_char = c;
    @(negedge clk);
    tx_valid = 0;
    @(negedge clk);
  endtask

  task automatic peer_take();
    peer_tx_mbox_clr = 1; peer_out_db_we = 1; peer_out_db_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    peer_tx_mbox_clr = 0; peer_out_db_we = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 0;
    peer_rx_mbox_we = 0; peer_rx_mbox_wdata = 0;
    peer_tx_mbox_clr = 0;
    peer_db_we = 0; peer_db_wdata = 0;
    peer_out_db_we = 0; peer_out_db_wdata = 0;
    tx_valid = 0; tx_char = 0; rx_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check(rx_mbox_q == 0, "R1 rx_mbox", rx_mbox_q, 0);
    check(tx_mbox_q == 0, "R1 tx_mbox", tx_mbox_q, 0);
    check(in_db_q == 0,   "R1 in_db", in_db_q, 0);
    check(out_db_q == 0,  "R1 out_db", out_db_q, 0);
    check(!connected,     "R1 connected", {31'b0, connected}, 0);
    check(!rx_avail,      "R1 rx_avail", {31'b0, rx_avail}, 0);
    check(tx_ready,       "R1 tx_ready", {31'b0, tx_ready}, 1);

    // R10 empty read strobe
    read_one();
    check(!rx_avail, "R10 empty read", {31'b0, rx_avail}, 0);

    // R6 connect, R11 consumed
    ring_db(32'h2);
    check(connected, "R6 connect", {31'b0, connected}, 1);
    check(in_db_q == 0, "R11 connect consumed", in_db_q, 0);

    // R7 R8 vector table
    for (int i = 0; i < 8; i++) begin
      send_word(VEC[i][39:8]);
      check(rx_mbox_q == 0, "R8 mailbox cleared", rx_mbox_q, 0);
      check(in_db_q == 0, "R11 data consumed", in_db_q, 0);
    end
    for (int i = 0; i < 8; i++) begin
      check(rx_avail, "R7 avail", {31'b0, rx_avail}, 1);
      check(rx_data == VEC[i][7:0], "R7 order", {24'b0, rx_data}, {24'b0, VEC[i][7:0]});
      read_one();
    end
    check(!rx_avail, "R7 drained", {31'b0, rx_avail}, 0);

    // R10 empty read does not move pointer
    read_one();
    send_word(32'h8000_0077);
    check(rx_data == 8'h77, "R10 pointer held", {24'b0, rx_data}, 32'h77);
    read_one();

    // R8 R9 fill to the near-full mark (pointers start at 9, so R7 wrap)
    for (int i = 0; i < 253; i++) begin
      send_word(32'h8000_0000 | {24'b0, 8'(i ^ 8'h5A)});
      if (i == 251) check(rx_mbox_q == 0, "R8 cleared at 252", rx_mbox_q, 0);
    end
    check(rx_mbox_q != 0, "R8 withheld at 253", rx_mbox_q, 32'h8000_0000 | {24'b0, 8'(252 ^ 8'h5A)});
    read_one();
    check(rx_mbox_q != 0, "R9 still withheld at 252", rx_mbox_q, 32'h8000_0000 | {24'b0, 8'(252 ^ 8'h5A)});
    read_one();
    check(rx_mbox_q == 0, "R9 released below 252", rx_mbox_q, 0);
    for (int i = 2; i < 253; i++) begin
      if (rx_data != 8'(i ^ 8'h5A))
        check(0, "R7 wrap order", {24'b0, rx_data}, {24'b0, 8'(i ^ 8'h5A)});
      read_one();
    end
    check(!rx_avail, "R7 wrap drained", {31'b0, rx_avail}, 0);

    // R5 alive echo
    ring_db(32'h1);
    check(out_db_q == 32'h1, "R5 alive echo", out_db_q, 1);
    check(in_db_q == 0, "R11 alive consumed", in_db_q, 0);
    peer_take();
    check(out_db_q == 0, "R5 echo cleared", out_db_q, 0);

    // R11 unknown code
    ring_db(32'h9);
    check(in_db_q == 0 && out_db_q == 0 && connected, "R11 unknown dropped", in_db_q, 0);

    // R2 transmit format
    tx_send(8'h41);
    check(tx_mbox_q == 32'h8000_0041, "R2 tx word", tx_mbox_q, 32'h8000_0041);
    check(out_db_q == 32'h5, "R2 tx doorbell", out_db_q, 5);

    // R3 wait while busy
    tx_send(8'h42);
    repeat (4) @(negedge clk);
    check(tx_mbox_q == 32'h8000_0041, "R3 held while busy", tx_mbox_q, 32'h8000_0041);
    peer_take();
    check(tx_mbox_q == 32'h8000_0042, "R3 sent when free", tx_mbox_q, 32'h8000_0042);
    peer_take();

    // R4 newline then return
    tx_send(8'h0A);
    check(tx_mbox_q == 32'h8000_000A, "R4 newline", tx_mbox_q, 32'h8000_000A);
    check(!tx_ready, "R4 busy for return", {31'b0, tx_ready}, 0);
    peer_take();
    check(tx_mbox_q == 32'h8000_000D, "R4 return", tx_mbox_q, 32'h8000_000D);
    peer_take();
    @(negedge clk);
    check(tx_mbox_q == 0 && tx_ready, "R4 nothing extra", tx_mbox_q, 0);

    // R6 disconnect then connect flush
    ring_db(32'h3);
    check(!connected, "R6 disconnect", {31'b0, connected}, 0);
    send_word(32'h8000_0011);
    send_word(32'h8000_0022);
    check(rx_avail, "R6 data before flush", {31'b0, rx_avail}, 1);
    ring_db(32'h2);
    check(!rx_avail, "R6 flush", {31'b0, rx_avail}, 0);
    check(connected, "R6 reconnect", {31'b0, connected}, 1);

    summary();
  end

endmodule